// File: doc/BRIEF.md
# Display Command-Word Transmit Engine

This block feeds a display panel over a four-wire serial link: a clock, a data line, an active-low chip select and a data/command select line. It pulls 32-bit words from the output side of a transmit FIFO with a valid/ready handshake. The first word of every transfer is a descriptor that sets the payload byte count, the level of the data/command line, the byte-swap group size and whether a completion pulse is wanted. The words after it carry the payload, four bytes per word. If the count is not a multiple of four, the last word holds only the leftover bytes, starting at its least significant byte.

The engine unpacks each payload word into bytes and reorders them when swapping is enabled. Each byte goes out most significant bit first with clock polarity 0 and phase 0. Chip select stays asserted for the whole payload of one descriptor, and a one-cycle completion pulse follows the last bit. Descriptors that request a receive are consumed and dropped.

The control sequencer has five states. IDLE takes a descriptor; a transmit descriptor moves it to FETCH. FETCH waits for a payload word and then moves to LOAD. LOAD hands one byte to the serializer and moves to SHIFT. When the byte has finished, SHIFT moves to GAP after the last byte of the descriptor, to FETCH after the last valid byte of a word, and back to LOAD otherwise. GAP releases chip select, raises the completion pulse if it was requested, and returns to IDLE.

Top module: `cwt_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, cmd_done is 0 and fifo_ready is 1.
- R2: A descriptor with bit 31 = 1 (transmit) starts a transfer of exactly (bits 17:0) + 1 payload bytes, taken from the FIFO words that follow it.
- R3: A descriptor with bit 31 = 0 is consumed and has no effect: chip select stays high, no clock toggles, and the next FIFO word is decoded as a descriptor.
- R4: spi_dc equals descriptor bit 30 (0 = command, 1 = data) for every payload byte, and it does not change while chip select is low.
- R5: With swap_en = 0, the bytes of each payload word go out least significant byte (bits 7:0) first.
- R6: With swap_en = 1, descriptor bits 28:27 set the swap group: 0 = single byte (no reorder), 1 = halfword (byte pairs reversed), 2 = word (all four bytes reversed), 3 = treated as 0.
- R7: When the byte count is not a multiple of 4, the final word supplies only the leftover bytes from bits 7:0 upward; with swapping, a group cut short is reversed over its valid bytes only.
- R8: Each byte is sent most significant bit first. spi_mosi is stable while spi_sck is high, spi_sck idles low, and spi_sck is high only while spi_cs_n is 0.
- R9: spi_cs_n falls exactly once per transmit descriptor, stays low across all of its payload words, and is high for at least one clock between descriptors.
- R10: cmd_done pulses high for exactly one clock after the last byte when descriptor bit 29 = 1, and stays low for a descriptor with bit 29 = 0.
- R11: fifo_ready is high only while the engine waits for a descriptor or for the next payload word, never while a byte is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| swap_en | input | 1 | Enables byte reordering within each format group |
| fifo_valid | input | 1 | FIFO holds a word |
| fifo_data | input | 32 | Descriptor or payload word |
| fifo_ready | output | 1 | Engine accepts the word this cycle |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data, MSB first |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_dc | output | 1 | Data/command select: 0 command, 1 data |
| cmd_done | output | 1 | One-cycle pulse when a transfer completes |

## Verification
The bench aims at transfers whose length ends in a partial word (1, 5, 6 and 7 bytes), combined with halfword and word swapping. A design that miscounted would shift an extra or a stale byte, and one that swapped the full group would send bytes that are not valid in the final word. A receive descriptor is followed directly by a transmit one to catch an engine that treats the next word as payload or toggles chip select. Chip-select falls are counted per descriptor to catch a select that is released between payload words or held across descriptors, and the completion pulse is counted with the enable bit both set and clear.

// File: rtl/cwt_pkg.sv
package cwt_pkg;

    localparam int DESC_W     = 32;
    localparam int LEN_W      = 18;
    localparam int WORD_BYTES = DESC_W / 8;

    typedef enum logic [1:0] {
        FMT_BYTE = 2'd0,
        FMT_HALF = 2'd1,
        FMT_WORD = 2'd2,
        FMT_RSVD = 2'd3
    } fmt_e;

    typedef struct packed {
        logic             tx;
        logic             dc;
        logic             done_en;
        fmt_e             fmt;
        logic             tmo;
        logic [1:0]       te;
        logic             rep;
        logic [1:0]       rsvd;
        logic [2:0]       dummy;
        logic [LEN_W-1:0] len;
    } desc_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_LOAD,
        S_SHIFT,
        S_GAP
    } state_e;

endpackage

// File: rtl/cwt_unpack.sv
module cwt_unpack
    import cwt_pkg::*;
#(
    parameter int NBYTES = WORD_BYTES
) (
    input  logic [8*NBYTES-1:0]       word,
    input  logic [$clog2(NBYTES)-1:0] idx,
    input  logic [$clog2(NBYTES):0]   nvalid,
    input  logic                      swap,
    input  fmt_e                      fmt,
    output logic [7:0]                byte_o
);

    localparam int IW = $clog2(NBYTES);
    localparam int BW = IW + 1;
    localparam logic [BW-1:0] ONE = BW'(1);
    localparam logic [BW-1:0] G2  = BW'(2);
    localparam logic [BW-1:0] G4  = BW'(NBYTES);

    logic [7:0]    lanes [NBYTES];
    logic [BW-1:0] gsz, base, rel, cnt, sel_w, idx_w;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    always_comb begin
        gsz = ONE;
        if (swap) begin
            unique case (fmt)
                FMT_HALF: gsz = G2;
                FMT_WORD: gsz = G4;
                default:  gsz = ONE;
            endcase
        end
        idx_w = {1'b0, idx};
        base  = idx_w & ~(gsz - ONE);
        rel   = idx_w - base;
        cnt   = nvalid - base;
        if (cnt > gsz) cnt = gsz;
        sel_w = base + cnt - ONE - rel;
    end

    assign byte_o = lanes[sel_w[IW-1:0]];

    always_comb begin
        if (nvalid != '0 && idx_w < nvalid)
            AST_SEL_IN_WORD: assert (sel_w < nvalid); // R7
    end

endmodule

// File: rtl/cwt_serial.sv
module cwt_serial #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] din,
    output logic       busy,
    output logic       done,
    output logic       sck,
    output logic       mosi
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] DIV_LAST = CW'(DIV - 1);

    logic [7:0]    sh;
    logic [2:0]    bitn;
    logic [CW-1:0] div_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            sck     <= 1'b0;
            sh      <= '0;
            bitn    <= '0;
            div_cnt <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    sh      <= din;
                    bitn    <= '0;
                    div_cnt <= '0;
                    sck     <= 1'b0;
                end
            end else if (div_cnt == DIV_LAST) begin
                div_cnt <= '0;
                if (!sck) begin
                    sck <= 1'b1;
                end else begin
                    sck <= 1'b0;
                    if (bitn == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        sh   <= {sh[6:0], 1'b0};
                        bitn <= bitn + 3'd1;
                    end
                end
            end else begin
                div_cnt <= div_cnt + CW'(1);
            end
        end
    end

    assign mosi = sh[7];

    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi)); // R8

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck); // R8

endmodule

// File: rtl/cwt_engine.sv
module cwt_engine
    import cwt_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swap_en,
    input  logic              fifo_valid,
    input  logic [DESC_W-1:0] fifo_data,
    output logic              fifo_ready,
    output logic              spi_sck,
    output logic              spi_mosi,
    output logic              spi_cs_n,
    output logic              spi_dc,
    output logic              cmd_done
);

    localparam int IW    = $clog2(WORD_BYTES);
    localparam int CNT_W = LEN_W + 1;
    localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] C_WB  = CNT_W'(WORD_BYTES);
    localparam logic [IW:0]      N_ONE = (IW+1)'(1);
    localparam logic [IW:0]      N_WB  = (IW+1)'(WORD_BYTES);

    state_e            state, state_nx;
    desc_t             desc;
    logic              dc_q, done_en_q;
    fmt_e              fmt_q;
    logic [CNT_W-1:0]  remain;
    logic [DESC_W-1:0] word_q;
    logic [IW-1:0]     idx;
    logic [IW:0]       nvalid;
    logic              cs_n_q;
    logic              ser_start, ser_busy, ser_done;
    logic [7:0]        cur_byte;
    logic              last_in_word;
    logic              unused_fields;

    assign desc          = desc_t'(fifo_data);
    assign unused_fields = ^{desc.tmo, desc.te, desc.rep, desc.rsvd, desc.dummy};
    assign last_in_word  = ({1'b0, idx} == (nvalid - N_ONE));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (fifo_valid && desc.tx) state_nx = S_FETCH;
            S_FETCH: if (fifo_valid) state_nx = S_LOAD;
            S_LOAD:  state_nx = S_SHIFT;
            S_SHIFT: if (ser_done) begin
                         if (remain == C_ONE)   state_nx = S_GAP;
                         else if (last_in_word) state_nx = S_FETCH;
                         else                   state_nx = S_LOAD;
                     end
            S_GAP:   state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dc_q      <= 1'b0;
            done_en_q <= 1'b0;
            fmt_q     <= FMT_BYTE;
            remain    <= '0;
            word_q    <= '0;
            idx       <= '0;
            nvalid    <= '0;
            cs_n_q    <= 1'b1;
        end else begin
            if (state == S_IDLE && fifo_valid && desc.tx) begin
                dc_q      <= desc.dc;
                done_en_q <= desc.done_en;
                fmt_q     <= desc.fmt;
                remain    <= {1'b0, desc.len} + C_ONE;
            end
            if (state == S_FETCH && fifo_valid) begin
                word_q <= fifo_data;
                idx    <= '0;
                nvalid <= (remain >= C_WB) ? N_WB : remain[IW:0];
            end
            if (state == S_SHIFT && ser_done) begin
                remain <= remain - C_ONE;
                idx    <= idx + IW'(1);
            end
            if (state == S_LOAD)     cs_n_q <= 1'b0;
            if (state_nx == S_GAP)   cs_n_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        fifo_ready = (state == S_IDLE) || (state == S_FETCH);
        ser_start  = (state == S_LOAD);
        cmd_done   = (state == S_GAP) && done_en_q;
        spi_cs_n   = cs_n_q;
        spi_dc     = dc_q;
    end

    cwt_unpack #(.NBYTES(WORD_BYTES)) u_unpack (
        .word   (word_q),
        .idx    (idx),
        .nvalid (nvalid),
        .swap   (swap_en),
        .fmt    (fmt_q),
        .byte_o (cur_byte)
    );

    cwt_serial #(.DIV(DIV)) u_serial (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ser_start),
        .din   (cur_byte),
        .busy  (ser_busy),
        .done  (ser_done),
        .sck   (spi_sck),
        .mosi  (spi_mosi)
    );

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done); // R10

    AST_NO_READY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        ser_busy |-> !fifo_ready); // R11

    AST_DC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && $past(!spi_cs_n)) |-> $stable(spi_dc)); // R4

    AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_cs_n); // R8

    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |=> spi_cs_n); // R9

    AST_FETCH_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH) |-> (remain != '0)); // R2

endmodule

// File: tb/sim_cwt_engine.sv
module sim_cwt_engine;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        swap_en = 1'b0;
    logic        fifo_valid = 1'b0;
    logic [31:0] fifo_data = '0;
    logic        fifo_ready, spi_sck, spi_mosi, spi_cs_n, spi_dc, cmd_done;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int cs_falls = 0;
    int byte_cnt = 0;
    string cur_tag = "R5";

    logic [8:0] exp_q [$];
    logic [7:0] mon_sh;
    int         mon_bits = 0;
    logic       prev_cs = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    cwt_engine #(.DIV(2)) u0 (
        .clk(clk), .rst_n(rst_n), .swap_en(swap_en),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_ready(fifo_ready),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
        .spi_dc(spi_dc), .cmd_done(cmd_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // serial receiver: captures bytes on rising clock edges
    always @(posedge spi_sck) begin
        mon_sh = {mon_sh[6:0], spi_mosi};
        mon_bits++;
        if (mon_bits == 8) begin
            mon_bits = 0;
            byte_cnt++;
            if (exp_q.size() == 0) begin
                chk(1'b0, cur_tag, "unexpected byte", int'(mon_sh), 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk(mon_sh == e[7:0], cur_tag, "byte value", int'(mon_sh), int'(e[7:0]));
                chk(spi_dc == e[8], "R4", "dc level", int'(spi_dc), int'(e[8]));
            end
        end
    end

    always @(posedge spi_cs_n) mon_bits = 0;

    // per-clock checks
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_done) done_cnt++;
            if (prev_cs && !spi_cs_n) cs_falls++;
            prev_cs = spi_cs_n;
            if (spi_sck) begin
                chk(!spi_cs_n, "R8", "sck high with cs released", int'(spi_cs_n), 0);
                chk(!fifo_ready, "R11", "ready while shifting", int'(fifo_ready), 0);
            end
        end
    end

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        fifo_valid = 1'b1;
        fifo_data  = w;
        while (!fifo_ready) @(negedge clk);
        @(negedge clk);
        fifo_valid = 1'b0;
    endtask

    function automatic logic [31:0] mk_desc(input bit tx, input bit dc, input bit den,
                                            input int fmt, input int nbytes);
        logic [31:0] d;
        d = '0;
        d[31]    = tx;
        d[30]    = dc;
        d[29]    = den;
        d[28:27] = fmt[1:0];
        d[17:0]  = 18'(nbytes - 1);
        return d;
    endfunction

    task automatic run_desc(input string tag, input bit sw, input bit dc, input bit den,
                            input int fmt, input int nbytes, input int seed);
        logic [7:0] pl [$];
        int g, d0, f0;
        swap_en = sw;
        cur_tag = tag;
        for (int i = 0; i < nbytes; i++) pl.push_back(8'(seed + 37 * i + 5));
        g = 1;
        if (sw && fmt == 1) g = 2;
        if (sw && fmt == 2) g = 4;
        for (int c = 0; c < nbytes; c += 4) begin
            int n;
            n = (nbytes - c < 4) ? nbytes - c : 4;
            for (int gb = 0; gb < n; gb += g) begin
                int cnt;
                cnt = (n - gb < g) ? n - gb : g;
                for (int k = cnt - 1; k >= 0; k--) exp_q.push_back({dc, pl[c + gb + k]});
            end
        end
        d0 = done_cnt;
        f0 = cs_falls;
        push(mk_desc(1'b1, dc, den, fmt, nbytes));
        for (int c = 0; c < nbytes; c += 4) begin
            logic [31:0] w;
            w = '0;
            for (int k = 0; k < 4 && c + k < nbytes; k++) w[8*k +: 8] = pl[c + k];
            push(w);
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R9", "cs released after transfer", int'(spi_cs_n), 1);
        chk(cs_falls - f0 == 1, "R9", "cs falls per descriptor", cs_falls - f0, 1);
        chk(done_cnt - d0 == (den ? 1 : 0), "R10", "done pulses", done_cnt - d0, den ? 1 : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1", "cs in reset", int'(spi_cs_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1", "cs after reset", int'(spi_cs_n), 1);
        chk(spi_sck == 1'b0, "R1", "sck after reset", int'(spi_sck), 0);
        chk(cmd_done == 1'b0, "R1", "done after reset", int'(cmd_done), 0);
        chk(fifo_ready == 1'b1, "R1", "ready after reset", int'(fifo_ready), 1);

        // R2 R4: single command byte, dc low
        run_desc("R2", 1'b0, 1'b0, 1'b1, 0, 1, 8'h3c);
        // R5: LSB-first, data, halfword format without swap
        run_desc("R5", 1'b0, 1'b1, 1'b1, 1, 8, 8'h10);
        // R6: halfword swap
        run_desc("R6", 1'b1, 1'b1, 1'b1, 1, 8, 8'h21);
        // R6: word swap
        run_desc("R6", 1'b1, 1'b1, 1'b1, 2, 8, 8'h42);
        // R6: byte format and reserved format leave order unchanged
        run_desc("R6", 1'b1, 1'b1, 1'b1, 0, 4, 8'h55);
        run_desc("R6", 1'b1, 1'b0, 1'b1, 3, 4, 8'h66);
        // R7: partial last word with word swap and halfword swap
        run_desc("R7", 1'b1, 1'b1, 1'b1, 2, 7, 8'h77);
        run_desc("R7", 1'b1, 1'b1, 1'b1, 1, 5, 8'h88);
        // R10: no done pulse when disabled; partial word unswapped
        run_desc("R10", 1'b0, 1'b1, 1'b0, 0, 6, 8'h99);

        // R3: receive descriptor is dropped, next word is a descriptor
        begin
            int b0, f0, d0;
            b0 = byte_cnt; f0 = cs_falls; d0 = done_cnt;
            push(mk_desc(1'b0, 1'b1, 1'b1, 2, 3));
            repeat (20) @(negedge clk);
            chk(byte_cnt == b0, "R3", "bytes after rx descriptor", byte_cnt - b0, 0);
            chk(cs_falls == f0, "R3", "cs activity after rx descriptor", cs_falls - f0, 0);
            chk(done_cnt == d0, "R3", "done after rx descriptor", done_cnt - d0, 0);
            chk(fifo_ready == 1'b1, "R3", "ready after rx descriptor", int'(fifo_ready), 1);
        end
        run_desc("R3", 1'b0, 1'b0, 1'b1, 2, 13, 8'hab);
        // R2: longer transfer spanning several words
        run_desc("R2", 1'b1, 1'b1, 1'b1, 2, 18, 8'hc4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule